// File: doc/BRIEF.md
# Descriptor-Driven Memory Copy Engine

This block is the data mover behind one DMA channel. A pulse on `go_i` makes it read a four-word descriptor from memory. The descriptor holds a link to the next descriptor, a source address, a target address and a command word. The engine then copies data from source to target in bursts. Every burst is read in full into a local byte buffer before any of it is written back. The command word selects the element width, the burst size, whether each address advances, and which side is paced by a peripheral request line.

The engine reports four one-cycle events: start (descriptor loaded), end (length exhausted), end-of-receive (the peripheral withdrew its request part-way through a descriptor) and stop (the descriptor or the chain has finished). It can follow a chain of descriptors. It can also branch 32 bytes ahead when a compare flag is set, or halt after a single descriptor. The memory side is one word-wide valid/ready port with byte enables. Arbitration between channels and the bus fabric sit outside this block.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset the engine is idle. `run_o`, `mem_req_o` and `remain_o` are 0. While `run_o` is low no memory request is made. A `go_i` pulse while idle raises `run_o` and starts a descriptor fetch.
- R2: The descriptor is read from the link pointer with its low 4 bits cleared. 32 is added when pointer bit 1 and `cmp_i` are both 1. The four words are read from consecutive word addresses in this order: next pointer, source, target, command.
- R3: If command bit 22 is set, `evt_start_o` pulses for one cycle in the cycle after the last descriptor word is accepted.
- R4: Command bits 15:14 set the element width: 1 gives 1 byte, 2 gives 2 bytes, 3 or 0 gives 4 bytes. Memory lanes are little-endian: the byte at address a travels on lane a[1:0]. `mem_be_o` sets exactly the lanes of the element.
- R5: Command bit 29 marks the source as request-paced and bit 28 marks the target. A paced address has its low 2 bits cleared when the descriptor is loaded.
- R6: When either side is paced, no burst begins while `dreq_i` is low.
- R7: Command bits 17:16 hold a code c, and the burst size is 4<<c bytes. Each burst moves the smaller of the burst size and the remaining length. All reads of a burst come before its writes.
- R8: Command bit 31 advances the source address by the width after each element, and bit 30 does the same for the target. With the bit clear, the address is held.
- R9: A memory request keeps `mem_req_o`, `mem_addr_o` and `mem_we_o` stable until `mem_ready_i` accepts it.
- R10: `remain_o` shows command bits 12:0 and is rewritten after each burst. At zero length, `evt_end_o` pulses if command bit 21 is set, and `evt_stop_o` pulses. The engine then goes idle with `run_o` low if `chain_dis_i` is 1 or next-pointer bit 0 is 1. Otherwise it fetches the next descriptor.
- R11: When a burst leaves a nonzero length on a paced channel and `dreq_i` is low, `evt_eor_o` pulses. What follows depends on the enables:
  - With `eor_stop_i`, `evt_stop_o` pulses and the engine goes idle.
  - Otherwise, with `eor_jump_i` and `chain_dis_i` low, the next descriptor is fetched.
  - Otherwise the engine waits for the request.
- R12: A descriptor whose length is 0 completes at once and makes no data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start pulse, taken while idle |
| desc_ptr_i | input | ADDR_W | First link pointer |
| cmp_i | input | 1 | Compare status used for the 32-byte branch |
| chain_dis_i | input | 1 | Forbid further descriptor fetches |
| eor_stop_i | input | 1 | Stop on end-of-receive |
| eor_jump_i | input | 1 | Fetch next descriptor on end-of-receive |
| dreq_i | input | 1 | Peripheral request for paced transfers |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_be_o | output | 4 | Byte lane enables |
| mem_wdata_o | output | 32 | Write data, lane aligned |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| run_o | output | 1 | Channel running |
| remain_o | output | 13 | Remaining length in bytes |
| evt_start_o | output | 1 | Start event pulse |
| evt_end_o | output | 1 | End event pulse |
| evt_eor_o | output | 1 | End-of-receive event pulse |
| evt_stop_o | output | 1 | Stop event pulse |

## Verification
Assertions check on every cycle the properties that are visible in one or two cycles of state:
- the request hold rule;
- that lane enables always cover 1, 2 or 4 bytes;
- that a paced channel never starts a burst with its request low;
- that paced addresses come out of the fetch word-aligned;
- that the start event follows only the last descriptor word;
- that the idle engine is silent.

Only the bench scenarios can show that the copied bytes land at the right addresses across widths, burst splits, held addresses and unaligned bytes. The same holds for the 32-byte branch, chaining versus single-descriptor halts, and the three end-of-receive outcomes, where the remaining length is read back at the ports.

// File: rtl/dde_pkg.sv
package dde_pkg;
  localparam int LEN_W      = 13;
  localparam int B_SRC_INC  = 31;
  localparam int B_DST_INC  = 30;
  localparam int B_SRC_FLOW = 29;
  localparam int B_DST_FLOW = 28;
  localparam int B_START_EN = 22;
  localparam int B_END_EN   = 21;
  localparam int BST_LO     = 16;
  localparam int WID_LO     = 14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_POST
  } dde_state_e;

  function automatic logic [2:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [5:0] burst_bytes(input logic [1:0] code);
    return 6'd4 << code;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] wb, input logic [1:0] off);
    logic [3:0] m;
    m = (wb == 3'd1) ? 4'b0001 : (wb == 3'd2) ? 4'b0011 : 4'b1111;
    return m << off;
  endfunction
endpackage

// File: rtl/dde_lane_align.sv
module dde_lane_align (
  input  logic [1:0]  off_i,
  input  logic [31:0] rdata_i,
  input  logic [31:0] elem_i,
  output logic [31:0] elem_o,
  output logic [31:0] wdata_o
);
  // read: move lane off_i down to bit 0; write: move bit 0 up to lane off_i
  assign elem_o  = rdata_i >> {off_i, 3'b000};
  assign wdata_o = elem_i << {off_i, 3'b000};
endmodule

// File: rtl/dde_burst_buf.sv
module dde_burst_buf #(
  parameter int BUF_BYTES = 32,
  parameter int OFF_W     = 6
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [2:0]       wb_i,
  input  logic [31:0]      wr_elem_i,
  output logic [31:0]      rd_elem_o
);
  logic [7:0] byte_q [BUF_BYTES];

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_byte
    logic [OFF_W:0] rel;
    logic           we;
    assign rel = (OFF_W+1)'(i) - {1'b0, off_i};
    assign we  = wr_en_i && (rel < (OFF_W+1)'(wb_i));
    always_ff @(posedge clk) begin
      if (we) byte_q[i] <= wr_elem_i[{rel[1:0], 3'b000} +: 8];
    end
  end

  always_comb begin
    rd_elem_o = '0;
    for (int j = 0; j < 4; j++) begin
      if (int'(off_i) + j < BUF_BYTES) rd_elem_o[8*j +: 8] = byte_q[int'(off_i) + j];
    end
  end
endmodule

// File: rtl/dde_ctrl.sv
module dde_ctrl
  import dde_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 32,
  localparam int OFF_W    = $clog2(BUF_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] desc_ptr_i,
  input  logic              cmp_i,
  input  logic              chain_dis_i,
  input  logic              eor_stop_i,
  input  logic              eor_jump_i,
  input  logic              dreq_i,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic              buf_we_o,
  output logic [OFF_W-1:0]  buf_off_o,
  output logic [2:0]        elem_wb_o,
  output logic              run_o,
  output logic [LEN_W-1:0]  remain_o,
  output logic              evt_start_o,
  output logic              evt_end_o,
  output logic              evt_eor_o,
  output logic              evt_stop_o
);
  dde_state_e        st_q, st_d;
  logic [1:0]        fcnt_q, fcnt_d;
  logic [ADDR_W-1:0] base_q, base_d, ptr_q, ptr_d, src_q, src_d, dst_q, dst_d;
  logic [31:0]       cmd_q, cmd_d;
  logic [OFF_W-1:0]  chunk_q, chunk_d, boff_q, boff_d;
  logic              run_q, run_d;
  logic [3:0]        evt_q, evt_d;   // {stop, eor, end, start}

  logic [2:0]        wb;
  logic [OFF_W-1:0]  bsz;
  logic [LEN_W-1:0]  len;
  logic              paced;
  logic [OFF_W:0]    boff_nx;
  logic              last_elem;
  logic [ADDR_W-1:0] step;

  function automatic logic [ADDR_W-1:0] desc_base(input logic [ADDR_W-1:0] p, input logic c);
    return (p & ~ADDR_W'(15)) + ((p[1] && c) ? ADDR_W'(32) : ADDR_W'(0));
  endfunction

  assign wb        = elem_bytes(cmd_q[WID_LO +: 2]);
  assign bsz       = OFF_W'(burst_bytes(cmd_q[BST_LO +: 2]));
  assign len       = cmd_q[LEN_W-1:0];
  assign paced     = cmd_q[B_SRC_FLOW] | cmd_q[B_DST_FLOW];
  assign boff_nx   = {1'b0, boff_q} + (OFF_W+1)'(wb);
  assign last_elem = boff_nx >= {1'b0, chunk_q};
  assign step      = ADDR_W'(wb);

  always_comb begin
    st_d = st_q; fcnt_d = fcnt_q; base_d = base_q; ptr_d = ptr_q;
    src_d = src_q; dst_d = dst_q; cmd_d = cmd_q; chunk_d = chunk_q;
    boff_d = boff_q; run_d = run_q; evt_d = '0;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = src_q; mem_be_o = 4'b0000;
    buf_we_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go_i) begin
          base_d = desc_base(desc_ptr_i, cmp_i);
          fcnt_d = 2'd0; run_d = 1'b1; st_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base_q + ADDR_W'({fcnt_q, 2'b00});
        mem_be_o   = 4'b1111;
        if (mem_ready_i) begin
          fcnt_d = fcnt_q + 2'd1;
          unique case (fcnt_q)
            2'd0: ptr_d = mem_rdata_i[ADDR_W-1:0];
            2'd1: src_d = mem_rdata_i[ADDR_W-1:0];
            2'd2: dst_d = mem_rdata_i[ADDR_W-1:0];
            default: begin
              cmd_d = mem_rdata_i;
              if (mem_rdata_i[B_SRC_FLOW]) src_d = src_q & ~ADDR_W'(3);
              if (mem_rdata_i[B_DST_FLOW]) dst_d = dst_q & ~ADDR_W'(3);
              evt_d[0] = mem_rdata_i[B_START_EN];
              st_d = ST_CHECK;
            end
          endcase
        end
      end
      ST_CHECK: begin
        if (len == '0) begin
          evt_d[1] = cmd_q[B_END_EN];
          evt_d[3] = 1'b1;
          if (chain_dis_i || ptr_q[0]) begin
            run_d = 1'b0; st_d = ST_IDLE;
          end else begin
            base_d = desc_base(ptr_q, cmp_i); fcnt_d = 2'd0; st_d = ST_FETCH;
          end
        end else if (!paced || dreq_i) begin
          chunk_d = (len < LEN_W'(bsz)) ? OFF_W'(len) : bsz;
          boff_d  = '0;
          st_d    = ST_READ;
        end
      end
      ST_READ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_q;
        mem_be_o   = lane_mask(wb, src_q[1:0]);
        if (mem_ready_i) begin
          buf_we_o = 1'b1;
          if (cmd_q[B_SRC_INC]) src_d = src_q + step;
          if (last_elem) begin
            boff_d = '0; st_d = ST_WRITE;
          end else begin
            boff_d = OFF_W'(boff_nx);
          end
        end
      end
      ST_WRITE: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = dst_q;
        mem_be_o   = lane_mask(wb, dst_q[1:0]);
        if (mem_ready_i) begin
          if (cmd_q[B_DST_INC]) dst_d = dst_q + step;
          if (last_elem) begin
            cmd_d[LEN_W-1:0] = len - LEN_W'(chunk_q);
            st_d = ST_POST;
          end else begin
            boff_d = OFF_W'(boff_nx);
          end
        end
      end
      default: begin   // ST_POST
        st_d = ST_CHECK;
        if (len != '0 && paced && !dreq_i) begin
          evt_d[2] = 1'b1;
          if (eor_stop_i) begin
            evt_d[3] = 1'b1; run_d = 1'b0; st_d = ST_IDLE;
          end else if (eor_jump_i && !chain_dis_i) begin
            base_d = desc_base(ptr_q, cmp_i); fcnt_d = 2'd0; st_d = ST_FETCH;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; fcnt_q <= '0; base_q <= '0; ptr_q <= '0; src_q <= '0;
      dst_q <= '0; cmd_q <= '0; chunk_q <= '0; boff_q <= '0; run_q <= 1'b0;
      evt_q <= '0;
    end else begin
      st_q <= st_d; fcnt_q <= fcnt_d; base_q <= base_d; ptr_q <= ptr_d;
      src_q <= src_d; dst_q <= dst_d; cmd_q <= cmd_d; chunk_q <= chunk_d;
      boff_q <= boff_d; run_q <= run_d; evt_q <= evt_d;
    end
  end

  assign buf_off_o   = boff_q;
  assign elem_wb_o   = wb;
  assign run_o       = run_q;
  assign remain_o    = len;
  assign evt_start_o = evt_q[0];
  assign evt_end_o   = evt_q[1];
  assign evt_eor_o   = evt_q[2];
  assign evt_stop_o  = evt_q[3];

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> !mem_req_o);
  p_start_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start_o |-> $past(st_q == ST_FETCH && fcnt_q == 2'd3 && mem_ready_i));
  p_lane_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                   $countones(mem_be_o) == 4));
  p_paced_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && $past(st_q == ST_FETCH) && cmd_q[B_SRC_FLOW]) |-> src_q[1:0] == 2'b00);
  p_no_burst_without_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && paced && !dreq_i && len != '0) |=> st_q != ST_READ);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dde_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] desc_ptr_i,
  input  logic              cmp_i,
  input  logic              chain_dis_i,
  input  logic              eor_stop_i,
  input  logic              eor_jump_i,
  input  logic              dreq_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              run_o,
  output logic [LEN_W-1:0]  remain_o,
  output logic              evt_start_o,
  output logic              evt_end_o,
  output logic              evt_eor_o,
  output logic              evt_stop_o
);
  localparam int OFF_W = $clog2(BUF_BYTES) + 1;

  logic             buf_we;
  logic [OFF_W-1:0] buf_off;
  logic [2:0]       elem_wb;
  logic [31:0]      elem_in, elem_out;

  dde_ctrl #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .desc_ptr_i(desc_ptr_i), .cmp_i(cmp_i),
    .chain_dis_i(chain_dis_i), .eor_stop_i(eor_stop_i), .eor_jump_i(eor_jump_i),
    .dreq_i(dreq_i), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .buf_we_o(buf_we), .buf_off_o(buf_off), .elem_wb_o(elem_wb),
    .run_o(run_o), .remain_o(remain_o), .evt_start_o(evt_start_o),
    .evt_end_o(evt_end_o), .evt_eor_o(evt_eor_o), .evt_stop_o(evt_stop_o)
  );

  dde_lane_align u_align (
    .off_i(mem_addr_o[1:0]), .rdata_i(mem_rdata_i), .elem_i(elem_out),
    .elem_o(elem_in), .wdata_o(mem_wdata_o)
  );

  dde_burst_buf #(.BUF_BYTES(BUF_BYTES), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .wr_en_i(buf_we), .off_i(buf_off), .wb_i(elem_wb),
    .wr_elem_i(elem_in), .rd_elem_o(elem_out)
  );
endmodule

// File: tb/dma_desc_engine_bench.sv
module dma_desc_engine_bench;
  typedef struct packed {
    logic [31:0] ptr;
    logic        cmp;
    logic [31:0] nxt;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] cmd;
    logic [3:0]  n_start;
    logic [3:0]  n_end;
  } vec_t;

  // cmd: 31/30 inc, 29/28 paced, 22 start, 21 end, 17:16 burst, 15:14 width, 12:0 len
  localparam vec_t TBL [0:6] = '{
    '{32'h000, 1'b0, 32'h1, 32'h100, 32'h200, 32'hC061_C010, 4'd1, 4'd1},
    '{32'h000, 1'b0, 32'h1, 32'h100, 32'h200, 32'hC023_4025, 4'd0, 4'd1},
    '{32'h000, 1'b0, 32'h1, 32'h100, 32'h200, 32'h8042_8014, 4'd1, 4'd0},
    '{32'h042, 1'b1, 32'h1, 32'h110, 32'h220, 32'hC023_C008, 4'd0, 4'd1},
    '{32'h000, 1'b0, 32'h1, 32'h100, 32'h200, 32'hC060_C000, 4'd1, 4'd1},
    '{32'h000, 1'b0, 32'h1, 32'h105, 32'h203, 32'hC001_4005, 4'd0, 4'd0},
    '{32'h042, 1'b0, 32'h1, 32'h120, 32'h240, 32'hC022_C00C, 4'd0, 4'd1}
  };

  logic clk, rst_n;
  logic go, cmp, chain_dis, eor_stop, eor_jump, dreq;
  logic [31:0] desc_ptr;
  logic mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic run, e_start, e_end, e_eor, e_stop;
  logic [12:0] remain;

  dma_desc_engine u_dma_desc_engine (
    .clk(clk), .rst_n(rst_n), .go_i(go), .desc_ptr_i(desc_ptr), .cmp_i(cmp),
    .chain_dis_i(chain_dis), .eor_stop_i(eor_stop), .eor_jump_i(eor_jump), .dreq_i(dreq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .run_o(run), .remain_o(remain), .evt_start_o(e_start), .evt_end_o(e_end),
    .evt_eor_o(e_eor), .evt_stop_o(e_stop)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory model
  logic [7:0]  mem [0:1023];
  logic [7:0]  expm [0:1023];
  logic        init_req, tb_we;
  logic [9:0]  tb_addr;
  logic [31:0] tb_data;
  logic [4:0]  lfsr;
  int          c_start, c_end, c_eor, c_stop, c_wr, mem_checks, mem_errs, cur_wb;

  function automatic logic [7:0] pat(input int i);
    return (i >= 256 && i < 512) ? 8'(i * 7 + 3) : 8'h00;
  endfunction

  assign mem_rdata = {mem[{mem_addr[9:2], 2'd3}], mem[{mem_addr[9:2], 2'd2}],
                      mem[{mem_addr[9:2], 2'd1}], mem[{mem_addr[9:2], 2'd0}]};

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else if (tb_we) begin
      for (int j = 0; j < 4; j++) mem[tb_addr + 10'(j)] <= tb_data[8*j +: 8];
    end else if (mem_req && mem_we && mem_ready) begin
      for (int j = 0; j < 4; j++)
        if (mem_be[j]) mem[{mem_addr[9:2], 2'(j)}] <= mem_wdata[8*j +: 8];
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 5'h1b;
    else lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
  end
  assign mem_ready = lfsr[0] | lfsr[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_start <= 0; c_end <= 0; c_eor <= 0; c_stop <= 0; c_wr <= 0;
      mem_checks <= 0; mem_errs <= 0;
    end else begin
      if (e_start) c_start <= c_start + 1;
      if (e_end)   c_end   <= c_end + 1;
      if (e_eor)   c_eor   <= c_eor + 1;
      if (e_stop)  c_stop  <= c_stop + 1;
      if (mem_req && mem_we && mem_ready) begin
        logic [3:0] m;
        m = (cur_wb == 1) ? 4'b0001 : (cur_wb == 2) ? 4'b0011 : 4'b1111;
        m = m << mem_addr[1:0];
        c_wr <= c_wr + 1;
        mem_checks <= mem_checks + 1;
        if (mem_be != m) begin
          mem_errs <= mem_errs + 1;
          $display("FAIL R4 write lanes at %h: actual %b expected %b", mem_addr, mem_be, m);
        end
      end
    end
  end

  int n_checks, n_err;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic poke(input logic [9:0] a, input logic [31:0] w);
    tb_addr = a; tb_data = w; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [9:0] a, input logic [31:0] n, s, d, c);
    poke(a, n); poke(a + 10'd4, s); poke(a + 10'd8, d); poke(a + 10'd12, c);
  endtask

  task automatic fresh_mem();
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    for (int i = 0; i < 1024; i++) expm[i] = pat(i);
  endtask

  // expected copy following R4/R5/R7/R8, applied to expm
  task automatic ref_copy(input logic [31:0] s0, d0, c, input int len);
    int s, d, wb, bs, chunk, ne;
    logic [7:0] tmp [0:31];
    s  = c[29] ? int'(s0 & ~32'h3) : int'(s0);
    d  = c[28] ? int'(d0 & ~32'h3) : int'(d0);
    wb = (c[15:14] == 2'd1) ? 1 : (c[15:14] == 2'd2) ? 2 : 4;
    bs = 4 << c[17:16];
    while (len > 0) begin
      chunk = (len < bs) ? len : bs;
      ne = (chunk + wb - 1) / wb;
      for (int e = 0; e < ne; e++) begin
        for (int j = 0; j < wb; j++) tmp[e*wb + j] = expm[(s + j) & 1023];
        if (c[31]) s += wb;
      end
      for (int e = 0; e < ne; e++) begin
        for (int j = 0; j < wb; j++) expm[(d + j) & 1023] = tmp[e*wb + j];
        if (c[30]) d += wb;
      end
      len -= chunk;
    end
  endtask

  task automatic cmp_dst(input string tag);
    int bad, first;
    bad = 0; first = -1;
    for (int a = 512; a < 768; a++)
      if (mem[a] !== expm[a]) begin bad++; if (first < 0) first = a; end
    if (first < 0) check(1'b1, tag, "target bytes", 0, 0);
    else check(1'b0, tag, "target byte", {24'h0, mem[first]}, {24'h0, expm[first]});
  endtask

  task automatic pulse_go(input logic [31:0] p);
    desc_ptr = p; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    while (run && n < 5000) begin @(negedge clk); n++; end
    check(!run, tag, "engine returned to idle", {31'h0, run}, 0);
  endtask

  logic [31:0] da;
  int s0_start, s0_end, s0_eor, s0_stop, s0_wr;

  task automatic snap();
    s0_start = c_start; s0_end = c_end; s0_eor = c_eor; s0_stop = c_stop; s0_wr = c_wr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors",
             n_checks + mem_checks + 1, n_err + mem_errs + 1);
    $finish;
  end

  initial begin
    n_checks = 0; n_err = 0;
    go = 0; cmp = 0; chain_dis = 0; eor_stop = 0; eor_jump = 0; dreq = 1;
    desc_ptr = 0; init_req = 0; tb_we = 0; tb_addr = 0; tb_data = 0; cur_wb = 4;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(run == 1'b0, "R1", "run after reset", {31'h0, run}, 0);
    check(mem_req == 1'b0, "R1", "request after reset", {31'h0, mem_req}, 0);
    check(remain == 13'd0, "R1", "remaining after reset", {19'h0, remain}, 0);

    // table of single-descriptor runs: R2 R3 R4 R7 R8 R10 R12
    for (int k = 0; k < 7; k++) begin
      vec_t v;
      v = TBL[k];
      fresh_mem();
      for (int a = 0; a < 128; a += 4) poke(10'(a), 32'h0);
      da = (v.ptr & ~32'hF) + ((v.ptr[1] && v.cmp) ? 32'd32 : 32'd0);
      put_desc(da[9:0], v.nxt, v.src, v.dst, v.cmd);
      ref_copy(v.src, v.dst, v.cmd, int'(v.cmd[12:0]));
      cur_wb = (v.cmd[15:14] == 2'd1) ? 1 : (v.cmd[15:14] == 2'd2) ? 2 : 4;
      cmp = v.cmp;
      snap();
      pulse_go(v.ptr);
      wait_idle("R10");
      @(negedge clk);
      cmp_dst((k == 3 || k == 6) ? "R2" : (k == 5) ? "R4" : "R7");
      check(c_start - s0_start == int'(v.n_start), "R3", "start events",
            c_start - s0_start, {28'h0, v.n_start});
      check(c_end - s0_end == int'(v.n_end), "R10", "end events",
            c_end - s0_end, {28'h0, v.n_end});
      check(c_stop - s0_stop == 1, "R10", "stop events", c_stop - s0_stop, 1);
      check(remain == 13'd0, "R10", "remaining length", {19'h0, remain}, 0);
      if (k == 4) check(c_wr == s0_wr, "R12", "writes for zero length", c_wr - s0_wr, 0);
      if (k == 2) check(mem[10'h200] == expm[10'h200], "R8", "held target byte",
                        {24'h0, mem[10'h200]}, {24'h0, expm[10'h200]});
    end
    cmp = 0;

    // R5/R6: paced source waits for request, address aligned on load
    fresh_mem();
    put_desc(10'h000, 32'h1, 32'h103, 32'h200, 32'hE001_C010);
    ref_copy(32'h103, 32'h200, 32'hE001_C010, 16);
    cur_wb = 4; dreq = 1'b0;
    snap();
    pulse_go(32'h0);
    repeat (60) @(negedge clk);
    check(c_wr == s0_wr, "R6", "writes while request low", c_wr - s0_wr, 0);
    check(run == 1'b1, "R6", "still running while stalled", {31'h0, run}, 1);
    dreq = 1'b1;
    wait_idle("R6");
    @(negedge clk);
    cmp_dst("R5");

    // R11: end-of-receive with stop
    fresh_mem();
    put_desc(10'h000, 32'h1, 32'h100, 32'h200, 32'hD001_C020);
    eor_stop = 1'b1; dreq = 1'b1;
    snap();
    pulse_go(32'h0);
    begin
      int n;
      n = 0;
      while (c_wr - s0_wr < 2 && n < 2000) begin @(negedge clk); n++; end
    end
    dreq = 1'b0;
    wait_idle("R11");
    @(negedge clk);
    check(remain == 13'd24, "R11", "remaining after early stop", {19'h0, remain}, 24);
    check(c_eor - s0_eor == 1, "R11", "eor events", c_eor - s0_eor, 1);
    check(c_stop - s0_stop == 1, "R11", "stop events on eor", c_stop - s0_stop, 1);
    check(c_end == s0_end, "R11", "no end event", c_end - s0_end, 0);
    eor_stop = 1'b0;

    // R11: end-of-receive jumps to next descriptor
    fresh_mem();
    put_desc(10'h000, 32'h040, 32'h100, 32'h200, 32'hD041_C020);
    put_desc(10'h040, 32'h1, 32'h140, 32'h280, 32'hC041_C008);
    ref_copy(32'h100, 32'h200, 32'hD041_C020, 8);
    ref_copy(32'h140, 32'h280, 32'hC041_C008, 8);
    eor_jump = 1'b1; dreq = 1'b1;
    snap();
    pulse_go(32'h0);
    begin
      int n;
      n = 0;
      while (c_wr - s0_wr < 2 && n < 2000) begin @(negedge clk); n++; end
    end
    dreq = 1'b0;
    wait_idle("R11");
    @(negedge clk);
    check(c_start - s0_start == 2, "R11", "start events after jump", c_start - s0_start, 2);
    check(c_eor - s0_eor == 1, "R11", "eor events before jump", c_eor - s0_eor, 1);
    check(remain == 13'd0, "R11", "remaining after jumped descriptor", {19'h0, remain}, 0);
    cmp_dst("R11");
    eor_jump = 1'b0; dreq = 1'b1;

    // R10: chaining follows the link, single mode halts after one
    for (int m = 0; m < 2; m++) begin
      fresh_mem();
      put_desc(10'h000, 32'h010, 32'h100, 32'h200, 32'hC021_C008);
      put_desc(10'h010, 32'h1, 32'h120, 32'h240, 32'hC021_C008);
      ref_copy(32'h100, 32'h200, 32'hC021_C008, 8);
      if (m == 0) ref_copy(32'h120, 32'h240, 32'hC021_C008, 8);
      chain_dis = (m == 1);
      snap();
      pulse_go(32'h0);
      wait_idle("R10");
      @(negedge clk);
      check(c_stop - s0_stop == 2 - m, "R10", "stop events in chain", c_stop - s0_stop, 2 - m);
      check(c_end - s0_end == 2 - m, "R10", "end events in chain", c_end - s0_end, 2 - m);
      cmp_dst("R10");
    end
    chain_dis = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors",
             n_checks + mem_checks, n_err + mem_errs);
    $finish;
  end
endmodule